// File: doc/BRIEF.md
# Byte-wide parallel flash command sequencer

This block is a synthesizable model of a byte-wide parallel flash part. It sits behind an asynchronous-style bus with active-low chip select, read strobe and write strobe. The strobes are sampled on a system clock and decoded into write events. A command state machine turns multi-write unlock sequences into these operations:

- program one byte,
- erase the whole chip,
- permanently write-protect the low boot sector,
- enter and leave an identification read mode.

Program, erase and protect run for a fixed number of clock cycles. While one of them runs, any read returns a polling status word in place of array data.

The array keeps two regions: the boot sector (addresses below `BOOT_BYTES`) and the main block. Each region holds `2**(MEM_AW-1)` bytes, and higher address bits within a region alias onto the same byte. A low `rst_n` models a fresh blank part. It sets every byte to 0xFF and clears the protection. Nothing else can clear the protection.

Top module: `pflash_seq`

## Requirements
- R1: `rdata_en` is 1 only while `cs_n`=0, `rd_n`=0 and `wr_n`=1. Whenever `rdata_en` is 0, `rdata` is 0x00.
- R2: After reset every byte reads 0xFF, the part is in normal read mode and the boot protection is off.
- R3: Writing 0xAA to 0x05555, then 0x55 to 0x02AAA, then 0xA0 to 0x05555, then (A, D) leaves byte A holding its old value AND D once the operation ends.
- R4: A write cycle lasts while `cs_n` and `wr_n` are both 0. Its address is the one present in the first sampled cycle of that window, and its data is the one present in the last sampled cycle.
- R5: Chip erase is six writes: 0xAA@0x05555, 0x55@0x02AAA, 0x80@0x05555, 0xAA@0x05555, 0x55@0x02AAA, 0x10@0x05555. Unless protection is on, it returns every byte to 0xFF.
- R6: A write whose address or data does not match the next expected step returns the sequencer to idle. The array is left untouched, and a later correct sequence works normally.
- R7: Busy timing and polling status:
  - A program or a protect stays busy for `PROG_CYC` cycles; an erase stays busy for `ERASE_CYC` cycles.
  - While busy, a read returns bit 7 as the complement of the target bit 7. For erase and protect the target bit 7 is 1.
  - While busy, bit 6 starts at 0 and inverts after each completed read. Bits 5:0 are 0.
  - From the cycle busy ends, reads return array data.
- R8: Writes that complete while an operation is busy are ignored. They change neither the array nor the command state.
- R9: After the unlock pair and 0x90@0x05555, reads return identification data: 0x00000 gives `MFR_CODE` (0xC5), 0x00001 gives `DEV_CODE` (0x35), 0x00002 gives the protection flag on bit 0 with bits 7:1 at 0, and any other address gives 0x00. The unlock pair and 0xF0@0x05555 restore array reads.
- R10: The six-write sequence ending in 0x40 (instead of 0x10) turns on boot protection, which then stays on until reset. While it is on, program and erase leave addresses 0x00000 to 0x01FFF unchanged, and main-block bytes still change as usual.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus and times operations |
| rst_n | input | 1 | Active-low reset; models a blank, unprotected part |
| bus_addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data from the host |
| rdata | output | 8 | Read data toward the host (0 when not driven) |
| rdata_en | output | 1 | Output-enable for `rdata` (high-impedance when 0) |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |

## Verification
The interesting collision is a read that is held steady while a program finishes. The same clock edge ends busy and writes the array, and the read path must switch from the polling word to the newly programmed byte exactly then. The bench holds the read across the whole busy window and checks three cycles: the first busy cycle, the last busy cycle and the first cycle after it. The second collision is a command sequence written entirely inside a busy window; the bench judges it by the array contents and by a later correct command that must still work.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

   typedef enum logic [2:0] {
      CS_IDLE,
      CS_KEY1,
      CS_KEY2,
      CS_PGM,
      CS_EXT1,
      CS_EXT2,
      CS_EXT3
   } cmd_state_e;

   typedef enum logic [1:0] {
      OP_NONE,
      OP_PGM,
      OP_ERASE,
      OP_LOCK
   } op_e;

   localparam logic [7:0] KEY_A    = 8'hAA;
   localparam logic [7:0] KEY_B    = 8'h55;
   localparam logic [7:0] CMD_PGM  = 8'hA0;
   localparam logic [7:0] CMD_EXT  = 8'h80;
   localparam logic [7:0] CMD_ERS  = 8'h10;
   localparam logic [7:0] CMD_LOCK = 8'h40;
   localparam logic [7:0] CMD_IDIN = 8'h90;
   localparam logic [7:0] CMD_IDEX = 8'hF0;

   localparam int unsigned KEY_ADDR_A = 32'h0000_5555;
   localparam int unsigned KEY_ADDR_B = 32'h0000_2AAA;

endpackage

// File: rtl/pflash_buscap.sv
module pflash_buscap #(
   parameter int ADDR_W = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        wdata,
   output logic              wr_evt,
   output logic [ADDR_W-1:0] evt_addr,
   output logic [7:0]        evt_data,
   output logic              rd_end
);

   logic              wr_win;
   logic              rd_win;
   logic              wr_win_q;
   logic              rd_win_q;
   logic [ADDR_W-1:0] addr_hold;
   logic [7:0]        data_hold;

   assign wr_win = ~cs_n & ~wr_n;
   assign rd_win = ~cs_n & ~rd_n & wr_n;
   assign rd_end = rd_win_q & ~rd_win;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_win_q  <= 1'b0;
         rd_win_q  <= 1'b0;
         addr_hold <= '0;
         data_hold <= '0;
         wr_evt    <= 1'b0;
         evt_addr  <= '0;
         evt_data  <= '0;
      end else begin
         wr_win_q <= wr_win;
         rd_win_q <= rd_win;
         wr_evt   <= 1'b0;
         if (wr_win && !wr_win_q) begin
            addr_hold <= bus_addr;
         end
         if (wr_win) begin
            data_hold <= wdata;
         end
         if (!wr_win && wr_win_q) begin
            wr_evt   <= 1'b1;
            evt_addr <= addr_hold;
            evt_data <= data_hold;
         end
      end
   end

endmodule

// File: rtl/pflash_cmd.sv
module pflash_cmd
   import pflash_pkg::*;
#(
   parameter int ADDR_W = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_evt,
   input  logic [ADDR_W-1:0] evt_addr,
   input  logic [7:0]        evt_data,
   input  logic              busy,
   output op_e               req,
   output logic [ADDR_W-1:0] req_addr,
   output logic [7:0]        req_data,
   output logic              id_mode,
   output cmd_state_e        state
);

   localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(KEY_ADDR_A);
   localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(KEY_ADDR_B);

   cmd_state_e state_nx;
   logic       id_nx;
   logic       take;
   logic       at_a;
   logic       at_b;

   assign take     = wr_evt & ~busy;
   assign at_a     = (evt_addr == ADR_A);
   assign at_b     = (evt_addr == ADR_B);
   assign req_addr = evt_addr;
   assign req_data = evt_data;

   always_comb begin
      state_nx = state;
      id_nx    = id_mode;
      req      = OP_NONE;
      if (take) begin
         unique case (state)
            CS_IDLE: state_nx = (at_a && evt_data == KEY_A) ? CS_KEY1 : CS_IDLE;
            CS_KEY1: state_nx = (at_b && evt_data == KEY_B) ? CS_KEY2 : CS_IDLE;
            CS_KEY2: begin
               state_nx = CS_IDLE;
               if (at_a) begin
                  case (evt_data)
                     CMD_PGM:  state_nx = CS_PGM;
                     CMD_EXT:  state_nx = CS_EXT1;
                     CMD_IDIN: id_nx    = 1'b1;
                     CMD_IDEX: id_nx    = 1'b0;
                     default:  state_nx = CS_IDLE;
                  endcase
               end
            end
            CS_PGM: begin
               req      = OP_PGM;
               state_nx = CS_IDLE;
            end
            CS_EXT1: state_nx = (at_a && evt_data == KEY_A) ? CS_EXT2 : CS_IDLE;
            CS_EXT2: state_nx = (at_b && evt_data == KEY_B) ? CS_EXT3 : CS_IDLE;
            CS_EXT3: begin
               state_nx = CS_IDLE;
               if (at_a && evt_data == CMD_ERS) begin
                  req = OP_ERASE;
               end else if (at_a && evt_data == CMD_LOCK) begin
                  req = OP_LOCK;
               end
            end
            default: state_nx = CS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= CS_IDLE;
         id_mode <= 1'b0;
      end else begin
         state   <= state_nx;
         id_mode <= id_nx;
      end
   end

endmodule

// File: rtl/pflash_busy.sv
module pflash_busy
   import pflash_pkg::*;
#(
   parameter int ADDR_W    = 17,
   parameter int PROG_CYC  = 20,
   parameter int ERASE_CYC = 200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  op_e               req,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [7:0]        req_data,
   input  logic              rd_end,
   output logic              busy,
   output op_e               commit,
   output logic [ADDR_W-1:0] tgt_addr,
   output logic [7:0]        tgt_data,
   output logic              poll7,
   output logic              toggle
);

   localparam int LONGEST = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
   localparam int CW      = $clog2(LONGEST + 1);

   logic [CW-1:0] left;
   op_e           op_q;

   assign commit = (busy && left == '0) ? op_q : OP_NONE;
   assign poll7  = (op_q == OP_PGM) ? tgt_data[7] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         left     <= '0;
         op_q     <= OP_NONE;
         tgt_addr <= '0;
         tgt_data <= '0;
         toggle   <= 1'b0;
      end else if (busy) begin
         if (left == '0) begin
            busy <= 1'b0;
         end else begin
            left <= left - 1'b1;
         end
         if (rd_end) begin
            toggle <= ~toggle;
         end
      end else if (req != OP_NONE) begin
         busy     <= 1'b1;
         op_q     <= req;
         tgt_addr <= req_addr;
         tgt_data <= req_data;
         toggle   <= 1'b0;
         left     <= (req == OP_ERASE) ? CW'(ERASE_CYC - 1) : CW'(PROG_CYC - 1);
      end
   end

endmodule

// File: rtl/pflash_array.sv
module pflash_array
   import pflash_pkg::*;
#(
   parameter int ADDR_W     = 17,
   parameter int MEM_AW     = 11,
   parameter int BOOT_BYTES = 8192,
   parameter bit LOCK_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  op_e               commit,
   input  logic [ADDR_W-1:0] tgt_addr,
   input  logic [7:0]        tgt_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_byte,
   output logic              locked
);

   localparam int                OFF_W    = MEM_AW - 1;
   localparam int                DEPTH    = 2 ** MEM_AW;
   localparam int                HALF     = DEPTH / 2;
   localparam logic [ADDR_W-1:0] BOOT_TOP = ADDR_W'(BOOT_BYTES);

   logic [7:0] mem [DEPTH];

   function automatic logic [MEM_AW-1:0] slot(input logic [ADDR_W-1:0] a);
      return {(a >= BOOT_TOP), a[OFF_W-1:0]};
   endfunction

   logic tgt_boot;
   assign tgt_boot = (tgt_addr < BOOT_TOP);

   generate
      if (LOCK_EN) begin : g_lock
         logic lock_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lock_q <= 1'b0;
            end else if (commit == OP_LOCK) begin
               lock_q <= 1'b1;
            end
         end
         assign locked = lock_q;
      end else begin : g_nolock
         assign locked = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem[i] <= 8'hFF;
         end
      end else begin
         case (commit)
            OP_PGM: begin
               if (!(locked && tgt_boot)) begin
                  mem[slot(tgt_addr)] <= mem[slot(tgt_addr)] & tgt_data;
               end
            end
            OP_ERASE: begin
               for (int i = 0; i < DEPTH; i++) begin
                  if (!(locked && i < HALF)) begin
                     mem[i] <= 8'hFF;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign rd_byte = mem[slot(rd_addr)];

endmodule

// File: rtl/pflash_seq.sv
module pflash_seq
   import pflash_pkg::*;
#(
   parameter int         ADDR_W     = 17,
   parameter int         MEM_AW     = 11,
   parameter int         BOOT_BYTES = 8192,
   parameter int         PROG_CYC   = 20,
   parameter int         ERASE_CYC  = 200,
   parameter bit         LOCK_EN    = 1'b1,
   parameter logic [7:0] MFR_CODE   = 8'hC5,
   parameter logic [7:0] DEV_CODE   = 8'h35
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic              rdata_en,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n
);

   generate
      if (ADDR_W < 15) begin : g_bad_aw
         $error("ADDR_W must reach the unlock addresses");
      end
      if (MEM_AW < 2) begin : g_bad_mem
         $error("MEM_AW must be at least 2");
      end
      if ((2 ** (MEM_AW - 1)) > BOOT_BYTES) begin : g_bad_fold
         $error("each storage region must fit inside the boot sector size");
      end
      if (BOOT_BYTES >= (2 ** ADDR_W)) begin : g_bad_boot
         $error("boot sector must be smaller than the address space");
      end
      if (PROG_CYC < 1 || ERASE_CYC < 1) begin : g_bad_cyc
         $error("busy durations must be at least one cycle");
      end
   endgenerate

   logic              wr_evt;
   logic [ADDR_W-1:0] evt_addr;
   logic [7:0]        evt_data;
   logic              rd_end;
   op_e               req;
   logic [ADDR_W-1:0] req_addr;
   logic [7:0]        req_data;
   logic              id_mode;
   cmd_state_e        cmd_st;
   logic              busy;
   op_e               commit;
   logic [ADDR_W-1:0] tgt_addr;
   logic [7:0]        tgt_data;
   logic              poll7;
   logic              toggle;
   logic [7:0]        arr_byte;
   logic              locked;

   pflash_buscap #(.ADDR_W(ADDR_W)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n     (cs_n),
      .rd_n     (rd_n),
      .wr_n     (wr_n),
      .bus_addr (bus_addr),
      .wdata    (wdata),
      .wr_evt   (wr_evt),
      .evt_addr (evt_addr),
      .evt_data (evt_data),
      .rd_end   (rd_end)
   );

   pflash_cmd #(.ADDR_W(ADDR_W)) u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_evt   (wr_evt),
      .evt_addr (evt_addr),
      .evt_data (evt_data),
      .busy     (busy),
      .req      (req),
      .req_addr (req_addr),
      .req_data (req_data),
      .id_mode  (id_mode),
      .state    (cmd_st)
   );

   pflash_busy #(
      .ADDR_W    (ADDR_W),
      .PROG_CYC  (PROG_CYC),
      .ERASE_CYC (ERASE_CYC)
   ) u_busy (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .req_addr (req_addr),
      .req_data (req_data),
      .rd_end   (rd_end),
      .busy     (busy),
      .commit   (commit),
      .tgt_addr (tgt_addr),
      .tgt_data (tgt_data),
      .poll7    (poll7),
      .toggle   (toggle)
   );

   pflash_array #(
      .ADDR_W     (ADDR_W),
      .MEM_AW     (MEM_AW),
      .BOOT_BYTES (BOOT_BYTES),
      .LOCK_EN    (LOCK_EN)
   ) u_arr (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit   (commit),
      .tgt_addr (tgt_addr),
      .tgt_data (tgt_data),
      .rd_addr  (bus_addr),
      .rd_byte  (arr_byte),
      .locked   (locked)
   );

   logic [7:0] id_byte;

   always_comb begin
      if (bus_addr == ADDR_W'(0)) begin
         id_byte = MFR_CODE;
      end else if (bus_addr == ADDR_W'(1)) begin
         id_byte = DEV_CODE;
      end else if (bus_addr == ADDR_W'(2)) begin
         id_byte = {7'b0, locked};
      end else begin
         id_byte = 8'h00;
      end
   end

   assign rdata_en = ~cs_n & ~rd_n & wr_n;

   always_comb begin
      if (!rdata_en) begin
         rdata = 8'h00;
      end else if (busy) begin
         rdata = {~poll7, toggle, 6'b0};
      end else if (id_mode) begin
         rdata = id_byte;
      end else begin
         rdata = arr_byte;
      end
   end

endmodule

// File: rtl/pflash_seq_chk.sv
module pflash_seq_chk
   import pflash_pkg::*;
#(
   parameter int ERASE_CYC = 200
) (
   input logic       clk,
   input logic       rst_n,
   input logic       rd_n,
   input logic       rdata_en,
   input logic       busy,
   input logic       locked,
   input logic       wr_evt,
   input logic       id_mode,
   input cmd_state_e cmd_st,
   input op_e        req
);

   int busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_run <= 0;
      end else begin
         busy_run <= busy ? busy_run + 1 : 0;
      end
   end

   // R1
   rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_n |-> !rdata_en);

   // R10
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> locked);

   // R8
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_evt) |=> ($stable(cmd_st) && $stable(id_mode)));

   // R3
   busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req != OP_NONE));

   // R9
   id_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(id_mode) |-> !$past(busy));

   // R7
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_run <= ERASE_CYC);

endmodule

bind pflash_seq pflash_seq_chk #(.ERASE_CYC(ERASE_CYC)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_n     (rd_n),
   .rdata_en (rdata_en),
   .busy     (busy),
   .locked   (locked),
   .wr_evt   (wr_evt),
   .id_mode  (id_mode),
   .cmd_st   (cmd_st),
   .req      (req)
);

// File: tb/sim_pflash_seq.sv
module sim_pflash_seq;

   localparam int PROG  = 20;
   localparam int ERASE = 200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [16:0] bus_addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        rdata_en;
   logic        cs_n = 1'b1;
   logic        rd_n = 1'b1;
   logic        wr_n = 1'b1;

   int n_chk = 0;
   int n_err = 0;

   logic [7:0] model [int];
   bit         lock_m = 1'b0;

   always #5 clk = ~clk;

   pflash_seq #(.PROG_CYC(PROG), .ERASE_CYC(ERASE)) u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .wdata    (wdata),
      .rdata    (rdata),
      .rdata_en (rdata_en),
      .cs_n     (cs_n),
      .rd_n     (rd_n),
      .wr_n     (wr_n)
   );

   function automatic logic [7:0] exp_of(input int a);
      return model.exists(a) ? model[a] : 8'hFF;
   endfunction

   function automatic void model_pgm(input int a, input logic [7:0] d);
      if (!(lock_m && a < 'h2000)) model[a] = exp_of(a) & d;
   endfunction

   function automatic void model_erase();
      int keys[$];
      foreach (model[k]) keys.push_back(k);
      foreach (keys[i]) if (!(lock_m && keys[i] < 'h2000)) model.delete(keys[i]);
   endfunction

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s got %02h expected %02h", tag, got, exp);
      end
   endtask

   task automatic bus_write(input logic [16:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; wdata = d; cs_n = 1'b0; wr_n = 1'b0;
      @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic bus_read(input logic [16:0] a, output logic [7:0] d, output logic en);
      @(negedge clk);
      bus_addr = a; cs_n = 1'b0; rd_n = 1'b0;
      #1;
      d = rdata; en = rdata_en;
      @(negedge clk);
      cs_n = 1'b1; rd_n = 1'b1;
   endtask

   task automatic read_chk(input string tag, input logic [16:0] a, input logic [7:0] exp);
      logic [7:0] d;
      logic       en;
      bus_read(a, d, en);
      check({tag, " data"}, d, exp);
      check({tag, " enable"}, {7'b0, en}, 8'h01);
   endtask

   task automatic unlock();
      bus_write(17'h05555, 8'hAA);
      bus_write(17'h02AAA, 8'h55);
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic program_byte(input logic [16:0] a, input logic [7:0] d);
      unlock();
      bus_write(17'h05555, 8'hA0);
      bus_write(a, d);
      model_pgm(int'(a), d);
      wait_cyc(PROG + 4);
   endtask

   task automatic long_op(input logic [7:0] last);
      unlock();
      bus_write(17'h05555, 8'h80);
      unlock();
      bus_write(17'h05555, last);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [7:0] d;
      logic       en;
      void'($urandom(32'h5EED_0042));
      wait_cyc(3);
      rst_n = 1'b1;

      // R1 / R2: idle outputs and blank contents after reset
      #1;
      check("R1 idle data", rdata, 8'h00);
      check("R1 idle enable", {7'b0, rdata_en}, 8'h00);
      read_chk("R2 boot byte blank", 17'h00000, 8'hFF);
      read_chk("R2 main byte blank", 17'h04123, 8'hFF);

      // R1: select without read strobe, and read plus write strobe
      @(negedge clk);
      bus_addr = 17'h00000; cs_n = 1'b0; #1;
      check("R1 no read strobe", {7'b0, rdata_en}, 8'h00);
      check("R1 no read strobe data", rdata, 8'h00);
      rd_n = 1'b0; wr_n = 1'b0; wdata = 8'h00; #1;
      check("R1 write strobe blocks", {7'b0, rdata_en}, 8'h00);
      @(negedge clk);
      cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
      wait_cyc(2);

      // R9: identification mode, protection flag clear
      unlock(); bus_write(17'h05555, 8'h90);
      read_chk("R9 maker code", 17'h00000, 8'hC5);
      read_chk("R9 device code", 17'h00001, 8'h35);
      read_chk("R9 R2 protect flag off", 17'h00002, 8'h00);
      read_chk("R9 other address", 17'h00003, 8'h00);
      unlock(); bus_write(17'h05555, 8'hF0);
      read_chk("R9 exit restores array", 17'h00000, 8'hFF);

      // R3 / R7: program with polling status and toggling bit 6
      unlock(); bus_write(17'h05555, 8'hA0); bus_write(17'h04010, 8'h3C);
      model_pgm('h4010, 8'h3C);
      read_chk("R7 poll first read", 17'h04010, 8'h80);
      read_chk("R7 poll toggled", 17'h04010, 8'hC0);
      wait_cyc(PROG);
      read_chk("R3 programmed byte", 17'h04010, exp_of('h4010));
      program_byte(17'h04010, 8'hF0);
      read_chk("R3 AND with old value", 17'h04010, 8'h30);

      // R7: read held across completion
      unlock(); bus_write(17'h05555, 8'hA0); bus_write(17'h04020, 8'hA5);
      model_pgm('h4020, 8'hA5);
      bus_addr = 17'h04020; cs_n = 1'b0; rd_n = 1'b0;
      for (int k = 2; k <= PROG + 2; k++) begin
         @(negedge clk); #1;
         if (k == 2 || k == PROG + 1) check("R7 held read busy", rdata, 8'h00);
         if (k == PROG + 2) check("R7 held read completes", rdata, 8'hA5);
      end
      @(negedge clk);
      cs_n = 1'b1; rd_n = 1'b1;
      wait_cyc(2);

      // R4: address from first cycle, data from last cycle
      unlock(); bus_write(17'h05555, 8'hA0);
      @(negedge clk);
      bus_addr = 17'h04030; wdata = 8'h00; cs_n = 1'b0; wr_n = 1'b0;
      @(negedge clk);
      bus_addr = 17'h04031; wdata = 8'h5A;
      @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b1;
      model_pgm('h4030, 8'h5A);
      wait_cyc(PROG + 4);
      read_chk("R4 data from last cycle", 17'h04030, 8'h5A);
      read_chk("R4 address from first cycle", 17'h04031, 8'hFF);

      // R4: window opened by select after write strobe
      @(negedge clk);
      bus_addr = 17'h1FFFF; wdata = 8'h00; wr_n = 1'b0;
      @(negedge clk);
      bus_addr = 17'h05555; wdata = 8'hAA; cs_n = 1'b0;
      @(negedge clk);
      cs_n = 1'b1;
      @(negedge clk);
      wr_n = 1'b1;
      bus_write(17'h02AAA, 8'h55); bus_write(17'h05555, 8'hA0); bus_write(17'h04033, 8'h0F);
      model_pgm('h4033, 8'h0F);
      wait_cyc(PROG + 4);
      read_chk("R4 select-timed write", 17'h04033, 8'h0F);

      // R6: broken sequence leaves array untouched
      bus_write(17'h05555, 8'hAA); bus_write(17'h02AAB, 8'h55);
      bus_write(17'h05555, 8'hA0); bus_write(17'h04040, 8'h00);
      wait_cyc(PROG + 4);
      read_chk("R6 broken sequence ignored", 17'h04040, 8'hFF);
      program_byte(17'h04040, 8'h77);
      read_chk("R6 recovery program", 17'h04040, 8'h77);

      // R8: full command issued while busy is ignored
      unlock(); bus_write(17'h05555, 8'hA0); bus_write(17'h04050, 8'h0F);
      model_pgm('h4050, 8'h0F);
      unlock(); bus_write(17'h05555, 8'hA0); bus_write(17'h04060, 8'h00);
      wait_cyc(PROG + 4);
      read_chk("R8 target programmed", 17'h04050, 8'h0F);
      read_chk("R8 busy write ignored", 17'h04060, 8'hFF);
      program_byte(17'h04060, 8'h81);
      read_chk("R8 state intact after busy", 17'h04060, 8'h81);

      // R3: random programs across both regions
      for (int i = 0; i < 24; i++) begin
         int off = int'($urandom % 1024);
         int a   = ($urandom % 2) ? ('h4000 + off) : off;
         logic [7:0] dv = 8'($urandom);
         program_byte(17'(a), dv);
         read_chk("R3 random program", 17'(a), exp_of(a));
      end

      // R5 / R7: chip erase with polling
      program_byte(17'h00100, 8'h12);
      long_op(8'h10);
      read_chk("R7 erase poll", 17'h04010, 8'h00);
      read_chk("R7 erase poll toggled", 17'h04010, 8'h40);
      model_erase();
      wait_cyc(ERASE + 4);
      read_chk("R5 main erased", 17'h04010, 8'hFF);
      read_chk("R5 boot erased", 17'h00100, 8'hFF);

      // R10: protection enable
      program_byte(17'h00100, 8'h12);
      program_byte(17'h04100, 8'h34);
      long_op(8'h40);
      read_chk("R7 protect poll", 17'h00100, 8'h00);
      wait_cyc(PROG + 4);
      lock_m = 1'b1;
      unlock(); bus_write(17'h05555, 8'h90);
      read_chk("R10 R9 protect flag on", 17'h00002, 8'h01);
      unlock(); bus_write(17'h05555, 8'hF0);
      program_byte(17'h00100, 8'h00);
      read_chk("R10 boot program blocked", 17'h00100, 8'h12);
      program_byte(17'h01FFF, 8'h00);
      read_chk("R10 boot top blocked", 17'h01FFF, 8'hFF);
      program_byte(17'h02000, 8'h3C);
      read_chk("R10 main first byte open", 17'h02000, 8'h3C);
      long_op(8'h10);
      model_erase();
      wait_cyc(ERASE + 4);
      read_chk("R10 boot survives erase", 17'h00100, 8'h12);
      read_chk("R10 main erased", 17'h04100, 8'hFF);
      long_op(8'h10);
      wait_cyc(ERASE + 4);
      unlock(); bus_write(17'h05555, 8'h90);
      read_chk("R10 protect stays on", 17'h00002, 8'h01);
      unlock(); bus_write(17'h05555, 8'hF0);
      bus_read(17'h00100, d, en);
      check("R10 final boot byte", d, 8'h12);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule